// File: doc/BRIEF.md
# I2C Master Transmit Controller

This block is a single-master I2C transmit engine for a host that works through strobes and control fields. The host enables the block, picks master-transmit mode, sets how many data bits a frame carries and whether they leave MSB-first or LSB-first, and reads a bus-busy flag to make sure the bus is free. It then asks for a start condition. After that it writes one byte per frame: first the 7-bit slave address with the direction bit, then payload. The block drives SCL and SDA as open-drain lines through pull-low enables. It reads the real line levels back on separate inputs and samples the slave's acknowledge on the ninth clock of every frame.

Each completed event raises an interrupt-request flag. The same event also raises a transfer-ready flag, except for a stop. The interrupt output reflects the flag only while interrupts are enabled. Between frames the block holds SCL low and waits for the next data write or a stop request. A refused frame (NACK) leaves a status bit set. The block stays stalled in that case too, until software writes new data or requests a stop.

SCL comes from the system clock through a programmable divider. Each bit takes four phases of `div_val + 1` clocks.

Top module: `i2c_tx_master`

## Requirements
- R1: After reset, and on any cycle where `enable` is low, `scl_oe`, `sda_oe`, `bus_busy`, `irq_flag`, `tx_ready` and `nack_flag` are all 0.
- R2: A strobe on `cond_wr` with `cond_busy`=1, `cond_sel`=0, `mode_mtx`=1 and the bus idle starts a start condition and sets `bus_busy`. During the start, SDA falls while SCL is high, and then SCL is pulled low. The strobe is ignored when `cond_sel`=1, when `mode_mtx`=0, or when `bus_busy` is already set.
- R3: `irq` equals `irq_flag` when `irq_en`=1 and is 0 otherwise. `irq_clr` clears `irq_flag`. When an event sets the flag in the same cycle as `irq_clr`, the set wins.
- R4: The first frame after a start always carries 8 bits, MSB-first (`data_in[7]` first), whatever `bit_len` and `lsb_first` hold.
- R5: Every later frame carries N data bits, where N=8 when `bit_len`=0 and N=`bit_len` otherwise. With `lsb_first`=0 the bits sent are `data_in[7]` down to `data_in[8-N]`. With `lsb_first`=1 they are `data_in[0]` up to `data_in[N-1]`.
- R6: Outside start and stop, SDA changes only while SCL is low. Each SCL high time of a bit lasts exactly `2*(div_val+1)` clocks.
- R7: After the data bits, the block releases SDA for a ninth clock and samples it while SCL is high. `nack_flag` becomes 1 if SDA read high and 0 if it read low. `tx_ready` and `irq_flag` are then set.
- R8: While `tx_ready` is 1, SCL is held low and no clocks are issued, even after a NACK. A `data_wr` strobe in this state clears `tx_ready` and `nack_flag` and starts the next frame.
- R9: A strobe on `cond_wr` with `cond_busy`=0 and `cond_sel`=0, made while waiting between frames, produces a stop: SDA rises while SCL is high. At its end `bus_busy` clears and `irq_flag` is set. If `data_wr` arrives in the same cycle as such a stop strobe, the stop wins and no frame is sent.
- R10: A `data_wr` strobe while the bus is idle issues no SCL clocks and leaves the lines released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Block enable; low holds the engine idle |
| mode_mtx | input | 1 | Master-transmit mode select; needed for a start |
| bit_len | input | 3 | Data bits per frame (0 means 8) |
| lsb_first | input | 1 | 1 sends data LSB-first, 0 MSB-first |
| irq_en | input | 1 | Interrupt output enable |
| div_val | input | DIV_W | SCL phase length minus one, in clocks |
| cond_wr | input | 1 | Strobe: write the busy/select pair |
| cond_busy | input | 1 | Busy value written: 1 start, 0 stop |
| cond_sel | input | 1 | Start/stop select; must be 0 for the write to act |
| data_wr | input | 1 | Strobe: write the data register |
| data_in | input | 8 | Byte to transmit |
| irq_clr | input | 1 | Clear the interrupt-request flag |
| scl_in | input | 1 | SCL line level read back |
| sda_in | input | 1 | SDA line level read back |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| bus_busy | output | 1 | Bus-busy flag |
| irq_flag | output | 1 | Interrupt-request flag |
| tx_ready | output | 1 | Transfer-ready flag |
| nack_flag | output | 1 | Last frame was not acknowledged |
| irq | output | 1 | Interrupt request to the host |

## Verification
Two things can land on the same clock edge. A flag-setting event (start done, frame acknowledged, stop done) can meet a software clear of `irq_flag`, and a stop request can meet a data write while the block is waiting between frames. The first case is provoked by holding `irq_clr` high across a start condition. The bench expects `irq_flag` to read high for exactly one cycle, because the set wins and the clear acts on the next cycle. The second case is provoked by strobing the stop request and `data_wr` together. It is judged by a completed stop, a cleared `bus_busy` and no new acknowledge clock on the line.

// File: rtl/i2c_tx_pkg.sv
// Package: shared types for the I2C master transmit controller.
// Assumes: one engine per package user; the encodings are internal only.
package i2c_tx_pkg;

    // Sequencer states of the transmit engine
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_HOLD  = 3'd2,
        ST_BIT   = 3'd3,
        ST_ACK   = 3'd4,
        ST_STOP  = 3'd5
    } seq_state_t;

endpackage

// File: rtl/i2c_tick_gen.sv
// Phase tick generator: emits one tick every (div_val+1) clocks while run is high.
// Assumes: div_val is held steady during a transfer; run low restarts the count.
module i2c_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    // Count clocks within one SCL phase and wrap at the programmed limit
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt >= div_val) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt >= div_val);
endmodule

// File: rtl/i2c_tx_shifter.sv
// Transmit shift register: holds the frame byte and presents the next bit.
// Assumes: load and shift are never high together; order is fixed per frame.
module i2c_tx_shifter #(
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               shift,
    input  logic               lsb_in,
    input  logic [FRAME_W-1:0] data_in,
    output logic               tx_bit
);
    logic [FRAME_W-1:0] sh;
    logic               lsb_mode;

    // Capture the byte and its order on load, then move one place per bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh       <= '0;
            lsb_mode <= 1'b0;
        end else if (load) begin
            sh       <= data_in;
            lsb_mode <= lsb_in;
        end else if (shift) begin
            if (lsb_mode) begin
                sh <= {1'b0, sh[FRAME_W-1:1]};
            end else begin
                sh <= {sh[FRAME_W-2:0], 1'b0};
            end
        end
    end

    assign tx_bit = lsb_mode ? sh[0] : sh[FRAME_W-1];
endmodule

// File: rtl/i2c_tx_seq.sv
// Transmit sequencer: start, data bits, acknowledge, wait and stop, plus host flags.
// Assumes: tick marks the end of an SCL phase; each bit is four phases
// (low, high, high, low); the line outputs decode from registered state.
module i2c_tx_seq
    import i2c_tx_pkg::*;
#(
    parameter int FRAME_W = 8,
    parameter int LEN_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tick,
    input  logic             req_start,
    input  logic             req_stop,
    input  logic             data_wr,
    input  logic             irq_clr,
    input  logic [LEN_W-1:0] bit_len,
    input  logic             lsb_first,
    input  logic             tx_bit,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             sh_load,
    output logic             sh_order,
    output logic             sh_shift,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             bus_busy,
    output logic             irq_flag,
    output logic             tx_ready,
    output logic             nack_flag
);
    localparam int CNT_W = $clog2(FRAME_W + 1);

    seq_state_t       state;
    logic [1:0]       phase;
    logic [CNT_W-1:0] bits_left;
    logic             first_frame;
    logic [CNT_W-1:0] frame_len;
    logic             ack_high;
    logic             take_data;

    // Data frames use the programmed length, where a zero field means a full byte
    assign frame_len = (bit_len == '0) ? CNT_W'(FRAME_W) : CNT_W'(bit_len);
    // An acknowledge counts only if SCL really reads high and SDA reads low
    assign ack_high  = sda_in || !scl_in;
    // A data write is taken only while waiting and not overridden by a stop
    assign take_data = (state == ST_HOLD) && !req_stop && data_wr;

    assign sh_load  = take_data;
    assign sh_order = first_frame ? 1'b0 : lsb_first;
    assign sh_shift = (state == ST_BIT) && tick && (phase == 2'd3) && (bits_left != 1);

    // Main sequencer with flag updates; event sets override a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            state       <= ST_IDLE;
            phase       <= 2'd0;
            bits_left   <= '0;
            first_frame <= 1'b0;
            bus_busy    <= 1'b0;
            irq_flag    <= 1'b0;
            tx_ready    <= 1'b0;
            nack_flag   <= 1'b0;
        end else begin
            if (irq_clr) begin
                irq_flag <= 1'b0;
            end
            case (state)
                ST_IDLE: begin
                    if (req_start && !bus_busy) begin
                        state       <= ST_START;
                        phase       <= 2'd0;
                        bus_busy    <= 1'b1;
                        first_frame <= 1'b1;
                    end
                end
                ST_START: begin
                    if (tick) begin
                        if (phase == 2'd2) begin
                            state    <= ST_HOLD;
                            phase    <= 2'd0;
                            irq_flag <= 1'b1;
                            tx_ready <= 1'b1;
                        end else begin
                            phase <= phase + 2'd1;
                        end
                    end
                end
                ST_HOLD: begin
                    if (req_stop) begin
                        state    <= ST_STOP;
                        phase    <= 2'd0;
                        tx_ready <= 1'b0;
                    end else if (data_wr) begin
                        state       <= ST_BIT;
                        phase       <= 2'd0;
                        bits_left   <= first_frame ? CNT_W'(FRAME_W) : frame_len;
                        first_frame <= 1'b0;
                        tx_ready    <= 1'b0;
                        nack_flag   <= 1'b0;
                    end
                end
                ST_BIT: begin
                    if (tick) begin
                        if (phase == 2'd3) begin
                            phase <= 2'd0;
                            if (bits_left == 1) begin
                                state <= ST_ACK;
                            end else begin
                                bits_left <= bits_left - 1'b1;
                            end
                        end else begin
                            phase <= phase + 2'd1;
                        end
                    end
                end
                ST_ACK: begin
                    if (tick) begin
                        if (phase == 2'd2) begin
                            nack_flag <= ack_high;
                        end
                        if (phase == 2'd3) begin
                            state    <= ST_HOLD;
                            phase    <= 2'd0;
                            irq_flag <= 1'b1;
                            tx_ready <= 1'b1;
                        end else begin
                            phase <= phase + 2'd1;
                        end
                    end
                end
                ST_STOP: begin
                    if (tick) begin
                        if (phase == 2'd2) begin
                            state    <= ST_IDLE;
                            phase    <= 2'd0;
                            bus_busy <= 1'b0;
                            irq_flag <= 1'b1;
                        end else begin
                            phase <= phase + 2'd1;
                        end
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // Decode the open-drain pull enables from state and phase
    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        case (state)
            ST_START: begin
                scl_oe = (phase == 2'd2);
                sda_oe = (phase != 2'd0);
            end
            ST_HOLD: begin
                scl_oe = 1'b1;
            end
            ST_BIT: begin
                scl_oe = (phase == 2'd0) || (phase == 2'd3);
                sda_oe = !tx_bit;
            end
            ST_ACK: begin
                scl_oe = (phase == 2'd0) || (phase == 2'd3);
            end
            ST_STOP: begin
                scl_oe = (phase == 2'd0);
                sda_oe = (phase != 2'd2);
            end
            default: begin
                scl_oe = 1'b0;
                sda_oe = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/i2c_tx_master.sv
// Top: I2C master transmit controller with strobe/field host interface.
// Assumes: single master, no clock stretching; lines are open-drain and are
// read back through scl_in and sda_in.
module i2c_tx_master #(
    parameter int DIV_W   = 8,
    parameter int FRAME_W = 8,
    parameter int LEN_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             mode_mtx,
    input  logic [LEN_W-1:0] bit_len,
    input  logic             lsb_first,
    input  logic             irq_en,
    input  logic [DIV_W-1:0] div_val,
    input  logic             cond_wr,
    input  logic             cond_busy,
    input  logic             cond_sel,
    input  logic             data_wr,
    input  logic [7:0]       data_in,
    input  logic             irq_clr,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             bus_busy,
    output logic             irq_flag,
    output logic             tx_ready,
    output logic             nack_flag,
    output logic             irq
);
    logic tick;
    logic req_start;
    logic req_stop;
    logic sh_load;
    logic sh_order;
    logic sh_shift;
    logic tx_bit;

    // A busy write with the select bit clear asks for start (1) or stop (0)
    assign req_start = cond_wr && cond_busy && !cond_sel && mode_mtx;
    assign req_stop  = cond_wr && !cond_busy && !cond_sel;

    i2c_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (enable),
        .div_val (div_val),
        .tick    (tick)
    );

    i2c_tx_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (sh_load),
        .shift   (sh_shift),
        .lsb_in  (sh_order),
        .data_in (data_in[FRAME_W-1:0]),
        .tx_bit  (tx_bit)
    );

    i2c_tx_seq #(.FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .tick      (tick),
        .req_start (req_start),
        .req_stop  (req_stop),
        .data_wr   (data_wr),
        .irq_clr   (irq_clr),
        .bit_len   (bit_len),
        .lsb_first (lsb_first),
        .tx_bit    (tx_bit),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sh_load   (sh_load),
        .sh_order  (sh_order),
        .sh_shift  (sh_shift),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .bus_busy  (bus_busy),
        .irq_flag  (irq_flag),
        .tx_ready  (tx_ready),
        .nack_flag (nack_flag)
    );

    // Interrupt output is gated by the host enable
    assign irq = irq_flag && irq_en;
endmodule

// File: rtl/i2c_tx_checker.sv
// Checker: temporal rules on the controller's ports, bound to the top module.
// Assumes: rst_n is synchronous active-low; enable low aborts any transfer.
module i2c_tx_checker (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic scl_oe,
    input logic sda_oe,
    input logic bus_busy,
    input logic irq_flag,
    input logic tx_ready
);
    // R1: an idle bus leaves both lines released
    assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_busy |-> (!scl_oe && !sda_oe));

    // R6: SDA moves while SCL stays high only inside a start or stop
    assert_sda_high_scl_R6: assert property (@(posedge clk) disable iff (!rst_n || !enable)
        (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe))) |-> bus_busy);

    // R7: transfer-ready never rises without the interrupt-request flag
    assert_ready_irq_R7: assert property (@(posedge clk) disable iff (!rst_n || !enable)
        $rose(tx_ready) |-> irq_flag);

    // R8: while waiting for the host, SCL is held low
    assert_wait_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> scl_oe);

    // R9: the bus becomes free only at a completed stop
    assert_stop_end_R9: assert property (@(posedge clk) disable iff (!rst_n || !enable)
        $fell(bus_busy) |-> (irq_flag && !scl_oe && !sda_oe));
endmodule

bind i2c_tx_master i2c_tx_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .bus_busy (bus_busy),
    .irq_flag (irq_flag),
    .tx_ready (tx_ready)
);

// File: tb/i2c_tx_master_test.sv
// Bench: behavioural bus monitor and slave, checked on every clock, plus
// directed host sequences with expected bits computed from the requirements.
module i2c_tx_master_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       mode_mtx = 1'b0;
    logic [2:0] bit_len = 3'd0;
    logic       lsb_first = 1'b0;
    logic       irq_en = 1'b0;
    logic [7:0] div_val = 8'd1;
    logic       cond_wr = 1'b0;
    logic       cond_busy = 1'b0;
    logic       cond_sel = 1'b0;
    logic       data_wr = 1'b0;
    logic [7:0] data_in = 8'd0;
    logic       irq_clr = 1'b0;
    logic       scl_oe, sda_oe, bus_busy, irq_flag, tx_ready, nack_flag, irq;
    logic       slave_pull = 1'b0;
    wire        scl_line = !scl_oe;
    wire        sda_line = !(sda_oe || slave_pull);

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;

    // monitor state
    bit prev_scl = 1'b1;
    bit prev_sda = 1'b1;
    int starts = 0;
    int stops = 0;
    int frames = 0;
    int rises = 0;
    int bitcnt = 0;
    int exp_len = 8;
    bit ack_on = 1'b1;
    bit rose_seen = 1'b0;
    int high_cnt = 0;
    int flag_hi = 0;
    bit bits[$];

    always #10 clk = !clk;

    i2c_tx_master uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode_mtx(mode_mtx),
        .bit_len(bit_len), .lsb_first(lsb_first), .irq_en(irq_en),
        .div_val(div_val), .cond_wr(cond_wr), .cond_busy(cond_busy),
        .cond_sel(cond_sel), .data_wr(data_wr), .data_in(data_in),
        .irq_clr(irq_clr), .scl_in(scl_line), .sda_in(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .bus_busy(bus_busy),
        .irq_flag(irq_flag), .tx_ready(tx_ready), .nack_flag(nack_flag), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Per-clock monitor: decodes the bus, plays the slave, checks gating and timing
    always @(negedge clk) begin
        cycles++;
        if (rst_n && enable) begin
            if (irq !== (irq_flag && irq_en))
                check(1'b0, "R3 irq gating", int'(irq), int'(irq_flag && irq_en));
            if (irq_flag) flag_hi++;
            if (prev_scl && scl_line && prev_sda && !sda_line) begin
                starts++;
                bitcnt = 0;
                rose_seen = 1'b0;
            end
            if (prev_scl && scl_line && !prev_sda && sda_line) stops++;
            if (!prev_scl && scl_line) begin
                rises++;
                rose_seen = 1'b1;
                high_cnt = 1;
                if (bitcnt < exp_len) begin
                    bits.push_back(sda_line);
                    bitcnt++;
                end else begin
                    bitcnt = 0;
                    frames++;
                end
            end else if (scl_line) begin
                high_cnt++;
            end
            if (prev_scl && !scl_line) begin
                if (rose_seen && high_cnt != 2 * (int'(div_val) + 1))
                    check(1'b0, "R6 SCL high time", high_cnt, 2 * (int'(div_val) + 1));
                rose_seen = 1'b0;
                slave_pull <= (bitcnt == exp_len) && ack_on;
            end
        end else begin
            slave_pull <= 1'b0;
        end
        prev_scl = scl_line;
        prev_sda = sda_line;
    end

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        wait (cycles > 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic cond_pulse(input bit b, input bit s, input bit with_data);
        @(negedge clk); #1;
        cond_wr = 1'b1; cond_busy = b; cond_sel = s; data_wr = with_data;
        @(negedge clk); #1;
        cond_wr = 1'b0; data_wr = 1'b0;
    endtask

    task automatic wait_ready(input string req);
        int n = 0;
        while (!tx_ready && n < 3000) begin
            step(1);
            n++;
        end
        check(tx_ready == 1'b1, req, int'(tx_ready), 1);
    endtask

    task automatic wait_free(input string req);
        int n = 0;
        while (bus_busy && n < 3000) begin
            step(1);
            n++;
        end
        check(bus_busy == 1'b0, req, int'(bus_busy), 0);
    endtask

    function automatic bit exp_bit(input logic [7:0] d, input int i, input bit lsb, input bit first);
        if (first || !lsb) return d[7 - i];
        return d[i];
    endfunction

    // Send one frame and compare the decoded bits and the acknowledge result
    task automatic frame(input logic [7:0] d, input int n, input bit lsb, input bit first,
                         input bit ack, input string req);
        int fr0 = frames;
        exp_len = n;
        ack_on = ack;
        bits.delete();
        @(negedge clk); #1;
        data_in = d; data_wr = 1'b1;
        @(negedge clk); #1;
        data_wr = 1'b0;
        check(tx_ready == 1'b0, {req, " ready cleared"}, int'(tx_ready), 0);
        wait_ready(req);
        check(frames == fr0 + 1, {req, " ack clock"}, frames, fr0 + 1);
        check(bits.size() == n, {req, " bit count"}, bits.size(), n);
        for (int i = 0; i < n && i < bits.size(); i++)
            check(bits[i] == exp_bit(d, i, lsb, first), {req, " bit value"},
                  int'(bits[i]), int'(exp_bit(d, i, lsb, first)));
        check(nack_flag == !ack, "R7 ack sample", int'(nack_flag), int'(!ack));
        check(irq_flag == 1'b1, "R7 irq after frame", int'(irq_flag), 1);
    endtask

    initial begin
        int s0, r0, f0;
        step(5);
        // R1: reset state
        check(!scl_oe && !sda_oe && !bus_busy && !irq_flag && !tx_ready && !nack_flag,
              "R1 reset state", int'({scl_oe, sda_oe, bus_busy, irq_flag, tx_ready, nack_flag}), 0);
        rst_n = 1'b1;
        enable = 1'b1;
        step(3);

        // R2: start ignored with select bit set or outside transmit mode
        mode_mtx = 1'b1;
        cond_pulse(1'b1, 1'b1, 1'b0);
        step(20);
        check(bus_busy == 1'b0 && starts == 0, "R2 select=1 ignored", starts, 0);
        mode_mtx = 1'b0;
        cond_pulse(1'b1, 1'b0, 1'b0);
        step(20);
        check(bus_busy == 1'b0 && starts == 0, "R2 mode off ignored", starts, 0);
        mode_mtx = 1'b1;

        // R10: data write while idle issues no clocks
        r0 = rises;
        @(negedge clk); #1; data_wr = 1'b1; data_in = 8'hFF;
        @(negedge clk); #1; data_wr = 1'b0;
        step(40);
        check(rises == r0 && !scl_oe && !sda_oe, "R10 idle data ignored", rises, r0);

        // R2: start condition
        cond_pulse(1'b1, 1'b0, 1'b0);
        check(bus_busy == 1'b1, "R2 busy set at start", int'(bus_busy), 1);
        wait_ready("R2 start completes");
        check(starts == 1, "R2 SDA falls with SCL high", starts, 1);
        check(irq_flag == 1'b1 && irq == 1'b0, "R3 irq masked", int'(irq), 0);
        irq_en = 1'b1;
        step(1);
        check(irq == 1'b1, "R3 irq enabled", int'(irq), 1);
        @(negedge clk); #1; irq_clr = 1'b1;
        @(negedge clk); #1; irq_clr = 1'b0;
        check(irq_flag == 1'b0 && irq == 1'b0, "R3 irq clear", int'(irq_flag), 0);

        // R4: address frame ignores length and order settings
        bit_len = 3'd3; lsb_first = 1'b1;
        frame(8'hA5, 8, 1'b1, 1'b1, 1'b1, "R4 address frame");

        // R5: data frames with programmed length and order
        @(negedge clk); #1; irq_clr = 1'b1; @(negedge clk); #1; irq_clr = 1'b0;
        bit_len = 3'd0; lsb_first = 1'b1;
        frame(8'h3C, 8, 1'b1, 1'b0, 1'b1, "R5 8-bit lsb-first");
        bit_len = 3'd3; lsb_first = 1'b0;
        frame(8'hA0, 3, 1'b0, 1'b0, 1'b1, "R5 3-bit msb-first");
        div_val = 8'd3;
        bit_len = 3'd5; lsb_first = 1'b1;
        frame(8'h16, 5, 1'b1, 1'b0, 1'b1, "R5 5-bit lsb-first slow clock");

        // R7/R8: NACK, then stall until the host acts
        bit_len = 3'd0; lsb_first = 1'b0;
        frame(8'h5A, 8, 1'b0, 1'b0, 1'b0, "R7 nack frame");
        r0 = rises;
        step(60);
        check(rises == r0 && scl_oe && tx_ready, "R8 stall after nack", rises - r0, 0);
        check(nack_flag == 1'b1, "R8 nack held while stalled", int'(nack_flag), 1);
        frame(8'hC3, 8, 1'b0, 1'b0, 1'b1, "R8 new data after nack");
        check(nack_flag == 1'b0, "R8 nack cleared by data write", int'(nack_flag), 0);

        // R9: stop together with a data write; stop wins
        s0 = stops; f0 = frames;
        cond_pulse(1'b0, 1'b0, 1'b1);
        wait_free("R9 stop frees bus");
        step(20);
        check(stops == s0 + 1, "R9 SDA rises with SCL high", stops, s0 + 1);
        check(frames == f0, "R9 data dropped on stop", frames, f0);
        check(irq_flag == 1'b1 && !scl_oe && !sda_oe, "R9 stop flags", int'(irq_flag), 1);

        // R3: set beats a clear held in the same cycle
        @(negedge clk); #1; irq_clr = 1'b1;
        step(2);
        flag_hi = 0;
        exp_len = 8;
        cond_pulse(1'b1, 1'b0, 1'b0);
        wait_ready("R3 second start");
        step(3);
        check(flag_hi == 1, "R3 set wins over clear", flag_hi, 1);
        irq_clr = 1'b0;

        // R1: enable low aborts mid-frame
        bits.delete();
        @(negedge clk); #1; data_in = 8'h00; data_wr = 1'b1;
        @(negedge clk); #1; data_wr = 1'b0;
        step(10);
        enable = 1'b0;
        step(1);
        check(!scl_oe && !sda_oe && !bus_busy && !irq_flag && !tx_ready && !nack_flag,
              "R1 enable low clears", int'({scl_oe, sda_oe, bus_busy, irq_flag, tx_ready, nack_flag}), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule